// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind the serial protocol engine of a byte-wide nonvolatile memory. The engine first loads a starting address, then hands over data bytes one at a time. The block keeps each byte in a one-page staging buffer at the current in-page offset. It does not touch the array until the engine signals a stop condition.

On the stop, the block walks the staging buffer in ascending offset order. It issues one array write for every offset that received a byte, then holds a busy flag for a programmable write-cycle count. A low-voltage select picks a second, longer count. While the block is busy, every input from the protocol engine is ignored.

A write-protect pin masks the commit for the top of the array. That region is the upper half for arrays with address widths up to 11 bits, and the upper quarter for wider arrays. The pin is evaluated live during the commit and is never latched. The block also exposes the address that a following current-address read would use.

Top module: `pgwr_commit`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low and `cur_addr_o` is zero.
- R2: No array write happens before a stop. After a stop that follows at least one byte, each received offset is written exactly once, at page base plus offset, in ascending offset order, and `mem_we_o` is only high while `busy_o` is high.
- R3: The in-page offset (address bits [4:0]) advances by one after each byte and wraps from 31 to 0 within the same 32-byte page. A later byte at the same offset replaces the earlier one.
- R4: Offsets in the page that received no byte, and all other pages, keep their previous contents.
- R5: `busy_o` rises the cycle after the stop is taken and stays high for 32 + `WC_CYCLES` cycles, or 32 + `WC_CYCLES_LV` cycles when `low_volt_i` is 1.
- R6: While `busy_o` is high, `addr_set_i`, `data_vld_i` and `stop_i` have no effect: `cur_addr_o`, the array and the busy length are unchanged.
- R7: With `wp_i` = 1, no write lands where address bit [ADDR_W-1] is 1 (ADDR_W ≤ 11), or where bits [ADDR_W-1:ADDR_W-2] are both 1 (ADDR_W ≥ 12). With `wp_i` = 0 every address is writable. The busy period runs either way.
- R8: `wp_i` is taken at commit time and not at data time: a pin that is high during data but low at stop allows the writes, and the reverse blocks them.
- R9: When a transfer ends, `cur_addr_o` equals the page base with offset (start + bytes) mod 32. Write protection does not change it.
- R10: A stop with no data byte since the address load causes no write and no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_set_i | input | 1 | Load start address (page base and offset) |
| addr_i | input | ADDR_W | Start address |
| data_vld_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop strobe: ends the transfer and starts the commit |
| wp_i | input | 1 | Write-protect pin, live |
| low_volt_i | input | 1 | Select the longer write-cycle count |
| busy_o | output | 1 | Commit or write cycle in progress |
| cur_addr_o | output | ADDR_W | Address left for a current-address read |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
Two instances are driven in lockstep. One has an 8-bit address, where protection covers the upper half; the other has a 12-bit address, where it covers the upper quarter. The stimulus sweeps start offsets at and near the page end against transfer lengths of 0, 1, 5, 32 and 37 bytes. The 37-byte case separates correct in-page wrap-over from a carry into the next page, and the zero-length case separates a dummy-write stop from a real commit. Every combination of the pin level at data time and at stop time is applied to pages inside and outside the guarded regions, which shows whether the pin is sampled live and whether the region boundary depends on the array size. Junk strobes sent during the busy period must leave the address pointer, the array model and the busy length untouched.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  localparam int unsigned PAGE_BYTES = 32;
  localparam int unsigned OFS_W      = $clog2(PAGE_BYTES);
  typedef logic [OFS_W-1:0] ofs_t;
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_COMMIT, ST_HOLD} st_e;
endpackage

// File: rtl/pgwr_buffer.sv
module pgwr_buffer
  import pgwr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  ofs_t              wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  ofs_t              rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_hit_o,
  output logic              any_o
);
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] hit_q;

  // one staging slot per page offset; no reset needed on data
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_idx_i == ofs_t'(i))) slot_q[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hit_q <= '0;
    else if (clr_i)   hit_q <= '0;
    else if (wr_en_i) hit_q[wr_idx_i] <= 1'b1;
  end

  assign rd_data_o = slot_q[rd_idx_i];
  assign rd_hit_o  = hit_q[rd_idx_i];
  assign any_o     = |hit_q;
endmodule

// File: rtl/pgwr_guard.sv
module pgwr_guard #(
  parameter int unsigned QUARTER_FROM_W = 12,
  parameter int unsigned ADDR_W         = 8
) (
  input  logic       wp_i,
  input  logic [1:0] top_i,    // two most significant address bits
  output logic       blocked_o
);
  logic region;

  if (ADDR_W >= QUARTER_FROM_W) begin : g_quarter
    assign region = top_i[1] & top_i[0];
  end else begin : g_half
    logic unused_lo;
    assign unused_lo = top_i[0];
    assign region    = top_i[1];
  end

  assign blocked_o = wp_i & region;
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int unsigned WC_CYCLES    = 20000,
  parameter int unsigned WC_CYCLES_LV = 30000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic long_i,
  output logic expire_o
);
  localparam int unsigned WC_MAX = (WC_CYCLES_LV > WC_CYCLES) ? WC_CYCLES_LV : WC_CYCLES;
  localparam int unsigned CNT_W  = $clog2(WC_MAX + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= long_i ? CNT_W'(WC_CYCLES_LV) : CNT_W'(WC_CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expire_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
  import pgwr_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned WC_CYCLES    = 20000,
  parameter int unsigned WC_CYCLES_LV = 30000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_set_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_vld_i,
  input  logic [7:0]        data_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              low_volt_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o
);
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;

  st_e               st_q, st_d;
  ofs_t              ofs_q, idx_q;
  logic [PAGE_W-1:0] page_q;

  logic       open_q;
  logic       take_stop, take_addr, take_data, last_idx;
  logic       rd_hit, any_hit, blocked, tmr_start, tmr_expire;
  logic [7:0] rd_data;

  assign open_q    = (st_q == ST_IDLE) || (st_q == ST_FILL);
  // priority inside a transfer: stop, then address load, then data
  assign take_stop = (st_q == ST_FILL) && stop_i;
  assign take_addr = open_q && addr_set_i && !take_stop;
  assign take_data = (st_q == ST_FILL) && data_vld_i && !stop_i && !addr_set_i;
  assign last_idx  = (idx_q == ofs_t'(PAGE_BYTES - 1));
  assign tmr_start = (st_q == ST_COMMIT) && last_idx;

  pgwr_buffer #(.DATA_W(8)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (take_addr),
    .wr_en_i   (take_data),
    .wr_idx_i  (ofs_q),
    .wr_data_i (data_i),
    .rd_idx_i  (idx_q),
    .rd_data_o (rd_data),
    .rd_hit_o  (rd_hit),
    .any_o     (any_hit)
  );

  pgwr_guard #(.ADDR_W(ADDR_W)) u_guard (
    .wp_i      (wp_i),
    .top_i     (page_q[PAGE_W-1 -: 2]),
    .blocked_o (blocked)
  );

  pgwr_timer #(.WC_CYCLES(WC_CYCLES), .WC_CYCLES_LV(WC_CYCLES_LV)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tmr_start),
    .long_i   (low_volt_i),
    .expire_o (tmr_expire)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (take_addr) st_d = ST_FILL;
      ST_FILL:   if (take_stop) st_d = any_hit ? ST_COMMIT : ST_IDLE;
      ST_COMMIT: if (last_idx)  st_d = ST_HOLD;
      ST_HOLD:   if (tmr_expire) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      page_q <= '0;
      ofs_q  <= '0;
      idx_q  <= '0;
    end else begin
      st_q <= st_d;
      if (take_addr) begin
        page_q <= addr_i[ADDR_W-1:OFS_W];
        ofs_q  <= addr_i[OFS_W-1:0];
      end else if (take_data) begin
        ofs_q  <= ofs_q + ofs_t'(1);  // wraps inside the page
      end
      if (take_stop)               idx_q <= '0;
      else if (st_q == ST_COMMIT)  idx_q <= idx_q + ofs_t'(1);
    end
  end

  assign busy_o      = (st_q == ST_COMMIT) || (st_q == ST_HOLD);
  assign cur_addr_o  = {page_q, ofs_q};
  assign mem_we_o    = (st_q == ST_COMMIT) && rd_hit && !blocked;
  assign mem_addr_o  = {page_q, idx_q};
  assign mem_wdata_o = rd_data;
endmodule

// File: rtl/pgwr_commit_chk.sv
module pgwr_commit_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              wp_i,
  input logic              busy_o,
  input logic [ADDR_W-1:0] cur_addr_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  logic in_region;
  always_comb begin
    if (ADDR_W >= 12) in_region = mem_addr_o[ADDR_W-1] & mem_addr_o[ADDR_W-2];
    else              in_region = mem_addr_o[ADDR_W-1];
  end

  p_we_in_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  p_ascending_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o[4:0] > $past(mem_addr_o[4:0])));

  p_same_page_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[ADDR_W-1:5] == cur_addr_o[ADDR_W-1:5]));

  p_busy_after_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  p_addr_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cur_addr_o));

  p_protect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && wp_i) |-> !in_region);
endmodule

bind pgwr_commit pgwr_commit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_i     (stop_i),
  .wp_i       (wp_i),
  .busy_o     (busy_o),
  .cur_addr_o (cur_addr_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/tb_pgwr_commit.sv
module tb_pgwr_commit;
  localparam int WC    = 12;
  localparam int WC_LV = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        addr_set = 0, data_vld = 0, stop = 0, wp = 0, lv = 0;
  logic [11:0] addr = '0;
  logic [7:0]  data = '0;

  logic        busy1, we1, busy2, we2;
  logic [7:0]  cur1, a1, wd1, wd2;
  logic [11:0] cur2, a2;

  pgwr_commit #(.ADDR_W(8), .WC_CYCLES(WC), .WC_CYCLES_LV(WC_LV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_set_i(addr_set), .addr_i(addr[7:0]),
    .data_vld_i(data_vld), .data_i(data), .stop_i(stop), .wp_i(wp), .low_volt_i(lv),
    .busy_o(busy1), .cur_addr_o(cur1), .mem_we_o(we1), .mem_addr_o(a1), .mem_wdata_o(wd1));

  pgwr_commit #(.ADDR_W(12), .WC_CYCLES(WC), .WC_CYCLES_LV(WC_LV)) dut_q (
    .clk_i(clk), .rst_ni(rst_n), .addr_set_i(addr_set), .addr_i(addr),
    .data_vld_i(data_vld), .data_i(data), .stop_i(stop), .wp_i(wp), .low_volt_i(lv),
    .busy_o(busy2), .cur_addr_o(cur2), .mem_we_o(we2), .mem_addr_o(a2), .mem_wdata_o(wd2));

  // array models fed by the write ports
  logic [7:0] obs1 [256]  = '{default: 8'h00};
  logic [7:0] obs2 [4096] = '{default: 8'h00};
  logic [7:0] exp1 [256]  = '{default: 8'h00};
  logic [7:0] exp2 [4096] = '{default: 8'h00};
  int wr1 = 0, wr2 = 0;

  always @(posedge clk) begin
    if (we1) begin obs1[a1] <= wd1; wr1 <= wr1 + 1; end
    if (we2) begin obs2[a2] <= wd2; wr2 <= wr2 + 1; end
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic xfer(input int t, input int pg, input int start, input int n,
                      input bit wp_dat, input bit wp_stp, input bit low);
    int w1s, w2s, bl, exp_bl, exp_w1, exp_w2, bad, fa, fe;
    bit prot1, prot2;
    logic [11:0] base;
    base = 12'((pg << 5) | start);
    w1s = wr1; w2s = wr2;
    @(negedge clk); addr_set = 1; addr = base; wp = wp_dat; lv = low;
    @(negedge clk); addr_set = 0;
    for (int k = 0; k < n; k++) begin
      data_vld = 1; data = 8'(t * 29 + k * 13 + 7);
      @(negedge clk);
    end
    data_vld = 0;
    check(wr1 == w1s && wr2 == w2s, "R2 no write before stop", wr1 - w1s, 0);
    wp = wp_stp; stop = 1;
    @(negedge clk); stop = 0;
    bl = 0;
    while (busy1 && bl < 2000) begin
      bl++;
      addr_set = (bl >= 3 && bl <= 6); data_vld = addr_set; stop = (bl == 5);
      addr = 12'hFFF; data = 8'hA5;
      @(negedge clk);
    end
    addr_set = 0; data_vld = 0; stop = 0; addr = '0;
    @(negedge clk);
    // expected model
    prot1 = wp_stp && pg[2];
    prot2 = wp_stp && (pg[6:5] == 2'b11);
    for (int k = 0; k < n; k++) begin
      int off;
      off = (start + k) % 32;
      if (!prot1) exp1[((pg & 7) << 5) | off] = 8'(t * 29 + k * 13 + 7);
      if (!prot2) exp2[(pg << 5) | off]       = 8'(t * 29 + k * 13 + 7);
    end
    exp_bl = (n == 0) ? 0 : 32 + (low ? WC_LV : WC);
    exp_w1 = (n == 0 || prot1) ? 0 : ((n > 32) ? 32 : n);
    exp_w2 = (n == 0 || prot2) ? 0 : ((n > 32) ? 32 : n);
    if (n == 0) check(bl == exp_bl, "R10 no busy on empty stop", bl, exp_bl);
    else        check(bl == exp_bl, "R5 busy length", bl, exp_bl);
    check(busy2 == 0, "R5 busy low after cycle", busy2, 0);
    if (wp_dat != wp_stp)
      check(wr1 - w1s == exp_w1, "R8 live pin write count", wr1 - w1s, exp_w1);
    else if (prot1)
      check(wr1 - w1s == exp_w1, "R7 half guard write count", wr1 - w1s, exp_w1);
    else
      check(wr1 - w1s == exp_w1, "R2 write count", wr1 - w1s, exp_w1);
    check(wr2 - w2s == exp_w2, "R7 quarter guard write count", wr2 - w2s, exp_w2);
    // page content
    bad = 0; fa = 0; fe = 0;
    for (int o = 0; o < 32; o++) begin
      int ad;
      ad = ((pg & 7) << 5) | o;
      if (obs1[ad] !== exp1[ad]) begin
        if (bad == 0) begin fa = obs1[ad]; fe = exp1[ad]; end
        bad++;
      end
    end
    check(bad == 0, "R3 page content with wrap", fa, fe);
    bad = 0;
    for (int i = 0; i < 256; i++) if (obs1[i] !== exp1[i]) bad++;
    check(bad == 0, "R4 untouched bytes narrow", bad, 0);
    bad = 0;
    for (int i = 0; i < 4096; i++) if (obs2[i] !== exp2[i]) bad++;
    check(bad == 0, "R4 untouched bytes wide", bad, 0);
    check(cur1 == 8'(((pg & 7) << 5) | ((start + n) % 32)), "R9 current address",
          cur1, ((pg & 7) << 5) | ((start + n) % 32));
    check(cur2 == 12'((pg << 5) | ((start + n) % 32)), "R6 R9 address after busy junk",
          cur2, (pg << 5) | ((start + n) % 32));
  endtask

  int starts [4]  = '{0, 7, 29, 31};
  int lengths [5] = '{0, 1, 5, 32, 37};

  initial begin
    repeat (3) @(negedge clk);
    check(busy1 == 0 && busy2 == 0, "R1 busy after reset", busy1, 0);
    check(we1 == 0 && we2 == 0, "R1 write enable after reset", we1, 0);
    check(cur1 == 0 && cur2 == 0, "R1 current address after reset", cur2, 0);
    rst_n = 1;
    @(negedge clk);
    for (int si = 0; si < 4; si++)
      for (int li = 0; li < 5; li++)
        for (int w = 0; w < 4; w++) begin
          int t;
          t = (si * 5 + li) * 4 + w;
          xfer(t, (t * 37 + 3) % 128, starts[si], lengths[li], w[1], w[0], t[0]);
        end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule